// File: doc/BRIEF.md
# Parallel Capture-Port Burst Transmitter

This block pushes a burst of bytes from programmable logic into a microcontroller's parallel camera-capture input when that input runs in its compressed-image mode. The logic side is the bus master. It generates a free-running pixel clock, a frame-valid envelope (vertical sync) and an 8-bit data bus. The receiver samples the bus on rising pixel clock edges. No line sync is produced. The frame-valid signal brackets the whole burst in the same way a chip select brackets an SPI transfer.

A single-cycle start request, typically decoded from a slow serial control port, opens a burst. The burst carries a programmed number of 32-bit words. The block fetches these words through a plain read strobe and sends each word least significant byte first, one byte per pixel clock. Frame-valid rises one pixel clock before the first byte and falls one pixel clock after the last byte. A one-cycle completion pulse marks the fall. Outside a burst the data and frame-valid outputs are held at zero, so the outputs of several such transmitters can be merged with a bitwise OR.

Top module: `camBurstTx`

## Requirements
- R1: The pixel clock `pclk` toggles continuously, whether a burst is running or not. Its period is 2*`halfDiv` system clocks, and it starts low after reset.
- R2: `txData` and `vsync` change only on the system clock edge at which `pclk` falls, so they are stable at every rising `pclk` edge.
- R3: A `startReq` pulse accepted while idle, with nonzero `burstLen`, raises `vsync` at a falling `pclk` edge. During that first pixel clock `txData` is zero, and the first data byte follows on the next pixel clock.
- R4: A burst carries exactly 4*`burstLen` bytes. Word k supplies bits [7:0], [15:8], [23:16] and [31:24] on four consecutive pixel clocks, in that order, and words go out in fetch order.
- R5: After the last byte, `vsync` stays high for one more pixel clock with `txData` zero, then falls. `done` is high for exactly the single system cycle in which `vsync` has just fallen.
- R6: Whenever `vsync` is low, `txData` is zero.
- R7: A `startReq` that arrives while a burst is pending or running is ignored. It does not lengthen the burst and does not start another one.
- R8: A `startReq` with `burstLen` equal to zero is ignored: `vsync` stays low, no read is issued and no `done` is given.
- R9: Each burst issues exactly `burstLen` single-cycle `rdEn` pulses, all while `vsync` is high. `rdData` is taken on the cycle after each pulse.
- R10: A `halfDiv` value below 2 is treated as 2, which gives a pixel clock period of 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Single-cycle burst request |
| burstLen | input | 16 | Burst length in 32-bit words, taken when the request is accepted |
| halfDiv | input | 8 | Half pixel clock period in system clocks (minimum 2); change only while idle |
| rdEn | output | 1 | Word fetch strobe |
| rdData | input | 32 | Fetched word, valid on the cycle after `rdEn` and held until the next fetch |
| pclk | output | 1 | Free-running pixel clock |
| vsync | output | 1 | Frame-valid envelope around the burst |
| txData | output | 8 | Byte bus, zero when idle |
| done | output | 1 | One-cycle pulse as `vsync` falls |

## Verification
Bursts of one, three and four words are sent at three clock divisors. Single-word bursts expose faults in the lead and trail timing at the frame edges. Multi-word bursts check byte order within each word and prefetch ordering across words, and a different divisor for each shows that the byte timing follows the pixel clock and not the system clock. The pixel clock period is also measured while idle, including an undersized divisor. Two extra requests are tried: one issued during a running burst and one with a zero length. Both must leave the frame count, the read count and the completion count unchanged.

// File: rtl/camTxPkg.sv
package camTxPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SEND,
    ST_TRAIL
  } txState_e;

  // strobes from control to datapath, valid only on a falling pclk edge
  typedef struct packed {
    logic loadWord;
    logic shiftByte;
    logic clearData;
    logic vsyncSet;
    logic vsyncClr;
  } dpStrobe_t;

endpackage

// File: rtl/camTxClkGen.sv
module camTxClkGen #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] halfDiv,
  output logic             pclk,
  output logic             fallEvt
);

  logic [DIV_W-1:0] effHalf;
  logic [DIV_W-1:0] cnt;
  logic             pclkQ;
  logic             tick;

  assign effHalf = (halfDiv < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : halfDiv;
  assign tick    = (cnt >= effHalf - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      pclkQ <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      pclkQ <= ~pclkQ;
    end else begin
      cnt   <= cnt + DIV_W'(1);
    end
  end

  assign pclk    = pclkQ;
  assign fallEvt = tick & pclkQ;

endmodule

// File: rtl/camTxCtrl.sv
module camTxCtrl
  import camTxPkg::*;
#(
  parameter int LEN_W = 16,
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] burstLen,
  input  logic             fallEvt,
  output dpStrobe_t        strb,
  output logic             rdEn,
  output logic             done
);

  localparam int BIDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(BYTES - 1);

  txState_e          state, stateNxt;
  logic              pending;
  logic              clrPending;
  logic [LEN_W-1:0]  lenQ;
  logic [LEN_W-1:0]  wordsLeft, wordsLeftNxt;
  logic [BIDX_W-1:0] byteIdx, byteIdxNxt;
  logic              fetch;
  logic              accept;

  assign accept = startReq && (state == ST_IDLE) && !pending && (burstLen != '0);

  always_comb begin
    stateNxt     = state;
    wordsLeftNxt = wordsLeft;
    byteIdxNxt   = byteIdx;
    fetch        = 1'b0;
    clrPending   = 1'b0;
    strb         = '0;
    if (fallEvt) begin
      unique case (state)
        ST_IDLE: if (pending) begin
          stateNxt      = ST_LEAD;
          strb.vsyncSet = 1'b1;
          fetch         = 1'b1;
          clrPending    = 1'b1;
          wordsLeftNxt  = lenQ;
        end
        ST_LEAD: begin
          stateNxt      = ST_SEND;
          strb.loadWord = 1'b1;
          byteIdxNxt    = '0;
          wordsLeftNxt  = wordsLeft - LEN_W'(1);
          fetch         = (wordsLeft > LEN_W'(1));
        end
        ST_SEND: begin
          if (byteIdx == LAST_BYTE) begin
            if (wordsLeft == '0) begin
              stateNxt       = ST_TRAIL;
              strb.clearData = 1'b1;
            end else begin
              strb.loadWord = 1'b1;
              byteIdxNxt    = '0;
              wordsLeftNxt  = wordsLeft - LEN_W'(1);
              fetch         = (wordsLeft > LEN_W'(1));
            end
          end else begin
            strb.shiftByte = 1'b1;
            byteIdxNxt     = byteIdx + BIDX_W'(1);
          end
        end
        ST_TRAIL: begin
          stateNxt      = ST_IDLE;
          strb.vsyncClr = 1'b1;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pending   <= 1'b0;
      lenQ      <= '0;
      wordsLeft <= '0;
      byteIdx   <= '0;
      rdEn      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= stateNxt;
      wordsLeft <= wordsLeftNxt;
      byteIdx   <= byteIdxNxt;
      rdEn      <= fetch;
      done      <= strb.vsyncClr;
      if (accept) begin
        pending <= 1'b1;
        lenQ    <= burstLen;
      end else if (clrPending) begin
        pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/camTxDatapath.sv
module camTxDatapath
  import camTxPkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              rdEn,
  input  logic [WORD_W-1:0] rdData,
  output logic [BUS_W-1:0]  txData,
  output logic              vsync
);

  logic              captureNow;
  logic [WORD_W-1:0] wordReg;
  logic [WORD_W-1:0] shiftReg;
  logic [BUS_W-1:0]  dataQ;
  logic              vsyncQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      captureNow <= 1'b0;
      wordReg    <= '0;
      shiftReg   <= '0;
      dataQ      <= '0;
      vsyncQ     <= 1'b0;
    end else begin
      captureNow <= rdEn;
      if (captureNow) wordReg <= rdData;
      if (strb.loadWord) begin
        dataQ    <= wordReg[BUS_W-1:0];
        shiftReg <= wordReg >> BUS_W;
      end else if (strb.shiftByte) begin
        dataQ    <= shiftReg[BUS_W-1:0];
        shiftReg <= shiftReg >> BUS_W;
      end else if (strb.clearData) begin
        dataQ    <= '0;
      end
      if (strb.vsyncSet)      vsyncQ <= 1'b1;
      else if (strb.vsyncClr) vsyncQ <= 1'b0;
    end
  end

  assign txData = dataQ;
  assign vsync  = vsyncQ;

endmodule

// File: rtl/camBurstTx.sv
module camBurstTx
  import camTxPkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [LEN_W-1:0]  burstLen,
  input  logic [DIV_W-1:0]  halfDiv,
  output logic              rdEn,
  input  logic [WORD_W-1:0] rdData,
  output logic              pclk,
  output logic              vsync,
  output logic [BUS_W-1:0]  txData,
  output logic              done
);

  localparam int BYTES = WORD_W / BUS_W;

  logic      fallEvt;
  dpStrobe_t strb;

  camTxClkGen #(.DIV_W(DIV_W), .MIN_HALF(2)) u_clk (
    .clk(clk), .rstN(rstN), .halfDiv(halfDiv), .pclk(pclk), .fallEvt(fallEvt)
  );

  camTxCtrl #(.LEN_W(LEN_W), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .burstLen(burstLen),
    .fallEvt(fallEvt), .strb(strb), .rdEn(rdEn), .done(done)
  );

  camTxDatapath #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdEn(rdEn), .rdData(rdData),
    .txData(txData), .vsync(vsync)
  );

endmodule

// File: rtl/camBurstTxChk.sv
module camBurstTxChk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             pclk,
  input logic             vsync,
  input logic [BUS_W-1:0] txData,
  input logic             done,
  input logic             rdEn
);

  // R2
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txData) |-> $fell(pclk));

  // R2
  vsync_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vsync) |-> $fell(pclk));

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vsync |-> (txData == '0));

  // R3
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vsync) |-> (txData == '0));

  // R5
  done_at_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $fell(vsync));

  // R5
  drop_gives_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vsync) |-> done);

  // R9
  rd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> !rdEn);

  // R9
  rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> vsync);

endmodule

bind camBurstTx camBurstTxChk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .pclk(pclk), .vsync(vsync),
  .txData(txData), .done(done), .rdEn(rdEn)
);

// File: tb/sim_camBurstTx.sv
module sim_camBurstTx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] burstLen = '0;
  logic [7:0]  halfDiv = 8'd2;
  logic        rdEn;
  logic [31:0] rdData = '0;
  logic        pclk, vsync, done;
  logic [7:0]  txData;

  int checks = 0;
  int errors = 0;
  int rdCount = 0;
  int doneCount = 0;
  int frameCount = 0;
  int rdPtr = 0;
  int wrPtr = 0;

  logic [7:0] expQ[$];
  int         expLenQ[$];
  logic [7:0] frameBuf[$];
  bit         inFrame = 0;

  always #5 clk = ~clk;

  camBurstTx u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .burstLen(burstLen),
    .halfDiv(halfDiv), .rdEn(rdEn), .rdData(rdData), .pclk(pclk),
    .vsync(vsync), .txData(txData), .done(done)
  );

  function automatic logic [31:0] wordVal(int idx);
    return 32'h1F2E3D4C + 32'(idx) * 32'h01030507;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // word source
  always @(posedge clk) begin
    if (rstN && rdEn) begin
      rdData <= wordVal(rdPtr);
      rdPtr  <= rdPtr + 1;
      rdCount <= rdCount + 1;
    end
    if (rstN && done) doneCount <= doneCount + 1;
  end

  // monitor: receiver view, samples on rising pclk
  always @(posedge pclk) begin
    if (vsync) begin
      frameBuf.push_back(txData);
      inFrame = 1;
    end else if (inFrame) begin
      inFrame = 0;
      frameCount++;
      if (expLenQ.size() == 0) begin
        check(0, "R7", frameCount, 0);
      end else begin
        int n;
        bit bad;
        int badIdx;
        n = expLenQ.pop_front();
        // R3 R5: one empty pixel clock at each end of the frame
        check(frameBuf.size() == 4 * n + 2, "R4", frameBuf.size(), 4 * n + 2);
        check(frameBuf[0] == 8'd0 && frameBuf[frameBuf.size()-1] == 8'd0, "R3",
              int'(frameBuf[0]), 0);
        bad = 0;
        badIdx = 0;
        for (int i = 0; i < 4 * n; i++) begin
          logic [7:0] e;
          e = (expQ.size() > 0) ? expQ.pop_front() : 8'hxx;
          if (!bad && (i + 1 < frameBuf.size()) && frameBuf[i+1] !== e) begin
            bad = 1;
            badIdx = i;
          end
        end
        check(!bad, "R4", bad ? int'(frameBuf[badIdx+1]) : 0, 0);
      end
      frameBuf.delete();
    end
  end

  task automatic pulseStart(int len);
    @(negedge clk);
    burstLen = 16'(len);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic measurePeriod(int half, int expPer);
    int cnt;
    @(negedge clk);
    halfDiv = 8'(half);
    repeat (20) @(negedge clk);
    while (pclk) @(negedge clk);
    while (!pclk) @(negedge clk);
    cnt = 0;
    while (pclk) begin @(negedge clk); cnt++; end
    while (!pclk) begin @(negedge clk); cnt++; end
    check(cnt == expPer, (half < 2) ? "R10" : "R1", cnt, expPer);
  endtask

  task automatic runBurst(int len, int half, bit extraStart);
    int rd0, dn0, fr0, guard;
    @(negedge clk);
    halfDiv = 8'(half);
    rd0 = rdCount; dn0 = doneCount; fr0 = frameCount;
    for (int k = 0; k < len; k++) begin
      logic [31:0] w;
      w = wordVal(wrPtr + k);
      expQ.push_back(w[7:0]);
      expQ.push_back(w[15:8]);
      expQ.push_back(w[23:16]);
      expQ.push_back(w[31:24]);
    end
    wrPtr += len;
    expLenQ.push_back(len);
    pulseStart(len);
    if (extraStart) begin
      guard = 0;
      while (!vsync && guard < 1000) begin @(negedge clk); guard++; end
      repeat (3 * half) @(negedge clk);
      pulseStart(len + 2);  // R7: must be ignored
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    repeat (8 * half + 40) @(negedge clk);
    check(rdCount - rd0 == len, "R9", rdCount - rd0, len);
    check(doneCount - dn0 == 1, "R5", doneCount - dn0, 1);
    check(frameCount - fr0 == 1, extraStart ? "R7" : "R3", frameCount - fr0, 1);
    check(vsync == 1'b0 && txData == 8'd0, "R6", int'(txData), 0);
  endtask

  initial begin
    #(200000 * 10);
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R6 reset state
    check(vsync == 1'b0 && txData == 8'd0, "R6", int'(txData), 0);
    check(done == 1'b0, "R5", int'(done), 0);
    check(rdEn == 1'b0, "R9", int'(rdEn), 0);

    measurePeriod(3, 6);    // R1 idle
    measurePeriod(0, 4);    // R10
    measurePeriod(1, 4);    // R10

    runBurst(1, 2, 0);
    runBurst(3, 3, 0);
    runBurst(4, 5, 0);
    runBurst(1, 0, 0);      // R10 divisor clamp in a burst
    runBurst(2, 2, 1);      // R7

    begin : zero_len  // R8
      int rd0, dn0, fr0;
      bit sawV;
      rd0 = rdCount; dn0 = doneCount; fr0 = frameCount;
      sawV = 0;
      pulseStart(0);
      repeat (200) begin @(negedge clk); if (vsync) sawV = 1; end
      check(!sawV, "R8", int'(sawV), 0);
      check(rdCount == rd0 && doneCount == dn0, "R8", rdCount - rd0, 0);
      check(frameCount == fr0, "R8", frameCount - fr0, 0);
    end

    measurePeriod(4, 8);    // R1 after bursts
    check(expQ.size() == 0, "R4", expQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule